// File: doc/BRIEF.md
# Power-State Arbiter with Conversion Abort Flag

This block turns two sources of power-down control into one power state. One source is an external power-down pin, which is asynchronous to the block clock. The other is a pair of one-cycle software strobes that request power-up and power-down. The two sources do not have equal weight. A high pin always holds the device down, and a software wake-up cannot override it. A software sleep, however, takes effect even while the pin is low. The device can leave a software sleep in two ways: by a software wake-up, or by the pin going high and then low again.

The block also watches a conversion-active level. If the device enters power-down while a conversion is running, that conversion is lost. The block raises a result-invalid flag so that downstream logic treats the next data word as unreliable. The flag stays up until a conversion both starts and ends while the device is powered. The serial interface logic is modelled as always powered, so the block never gates its own clock or strobes.

Top module: `pd_arbiter`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `pwr_down_o` and `result_invalid_o` are both 0.
- R2: The pin passes through a synchronizer of SYNC_STAGES flops (default 2). After the pin has been sampled high at a rising edge, `pwr_down_o` is 1 once SYNC_STAGES edges have passed. It then stays 1 for as long as the synchronized pin is high.
- R3: A software power-up strobe has no effect while the synchronized pin is high, and `pwr_down_o` stays 1.
- R4: A software power-down strobe sets `pwr_down_o` to 1 from the next cycle on, whatever the pin level, unless R7 applies.
- R5: After a software power-down with the synchronized pin low, a power-up strobe (without a power-down strobe in the same cycle) returns `pwr_down_o` to 0 from the next cycle.
- R6: A falling edge of the synchronized pin cancels a pending software power-down. `pwr_down_o` returns to 0 once the pin has been high and then low again.
- R7: When a synchronized pin falling edge and a software power-down strobe fall in the same cycle, the pin wins and the device stays powered.
- R8: When power-up and power-down strobes arrive in the same cycle, power-down wins.
- R9: A cycle in which `pwr_down_o` rises while `conv_active_i` is 1 sets `result_invalid_o` from the next cycle.
- R10: `result_invalid_o` clears on the cycle after `conv_active_i` falls, provided that conversion began and ended with the device powered. A conversion that is interrupted by power-down does not clear it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pd_pin_i | input | 1 | Asynchronous power-down pin, high = down |
| sw_up_i | input | 1 | One-cycle software power-up strobe |
| sw_down_i | input | 1 | One-cycle software power-down strobe |
| conv_active_i | input | 1 | High while a conversion is in progress |
| pwr_down_o | output | 1 | Arbitrated power state, 1 = powered down |
| result_invalid_o | output | 1 | Next data word is unreliable |

## Verification
The bench aims strobes at the exact cycle in which the synchronized pin falls. A design with the wrong priority there would go to sleep when it should stay awake. It also sends a wake-up strobe while the pin is high, and a design that honoured it would drop `pwr_down_o` too early. Sleep and wake strobes are issued together, and a power-down is made to land inside an active conversion. A design that missed the abort would leave `result_invalid_o` low. A design that cleared the flag on any falling edge of the conversion-active level, including the one caused by the abort itself, would drop the flag too soon. Random pin and strobe traffic then runs against a cycle model.

// File: rtl/pd_pkg.sv
package pd_pkg;
  localparam int unsigned DEF_SYNC_STAGES = 2;

  typedef struct packed {
    logic level;
    logic rise;
    logic fall;
  } pin_evt_t;
endpackage

// File: rtl/pd_pin_sync.sv
module pd_pin_sync
  import pd_pkg::*;
#(
  parameter int unsigned STAGES = DEF_SYNC_STAGES
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     pin_i,
  output pin_evt_t evt_o
);
  localparam int unsigned N = (STAGES < 2) ? 2 : STAGES;

  logic [N-1:0] chain_q;
  logic         prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chain_q <= '0;
      prev_q  <= 1'b0;
    end else begin
      chain_q <= {chain_q[N-2:0], pin_i};
      prev_q  <= chain_q[N-1];
    end
  end

  always_comb begin
    evt_o.level = chain_q[N-1];
    evt_o.rise  = chain_q[N-1] & ~prev_q;
    evt_o.fall  = ~chain_q[N-1] & prev_q;
  end
endmodule

// File: rtl/pd_state_ctrl.sv
module pd_state_ctrl
  import pd_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  pin_evt_t pin_i,
  input  logic     sw_up_i,
  input  logic     sw_down_i,
  output logic     sw_off_o,
  output logic     pwr_down_o
);
  logic sw_off_q, sw_off_d;

  // pin fall beats software sleep; sleep beats wake; wake blocked by pin
  always_comb begin
    sw_off_d = sw_off_q;
    if (pin_i.fall)                    sw_off_d = 1'b0;
    else if (sw_down_i)                sw_off_d = 1'b1;
    else if (sw_up_i && !pin_i.level)  sw_off_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sw_off_q <= 1'b0;
    else         sw_off_q <= sw_off_d;
  end

  assign sw_off_o   = sw_off_q;
  assign pwr_down_o = sw_off_q | pin_i.level;
endmodule

// File: rtl/pd_abort_track.sv
module pd_abort_track (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pwr_down_i,
  input  logic conv_active_i,
  output logic invalid_o
);
  logic pd_q, act_q, run_ok_q, inv_q;
  logic pd_rise, act_rise, act_fall, abort, done_ok;

  assign pd_rise  = pwr_down_i & ~pd_q;
  assign act_rise = conv_active_i & ~act_q;
  assign act_fall = ~conv_active_i & act_q;
  assign abort    = pd_rise & conv_active_i;
  assign done_ok  = act_fall & run_ok_q & ~pwr_down_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pd_q     <= 1'b0;
      act_q    <= 1'b0;
      run_ok_q <= 1'b0;
      inv_q    <= 1'b0;
    end else begin
      pd_q  <= pwr_down_i;
      act_q <= conv_active_i;
      // run_ok: current conversion started and stayed powered
      if (pwr_down_i)    run_ok_q <= 1'b0;
      else if (act_rise) run_ok_q <= 1'b1;
      else if (act_fall) run_ok_q <= 1'b0;
      if (abort)        inv_q <= 1'b1;
      else if (done_ok) inv_q <= 1'b0;
    end
  end

  assign invalid_o = inv_q;
endmodule

// File: rtl/pd_arbiter.sv
module pd_arbiter
  import pd_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = DEF_SYNC_STAGES
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pd_pin_i,
  input  logic sw_up_i,
  input  logic sw_down_i,
  input  logic conv_active_i,
  output logic pwr_down_o,
  output logic result_invalid_o
);
  pin_evt_t pin_evt;
  logic     sw_off;
  logic     pd_int;

  pd_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pin_i  (pd_pin_i),
    .evt_o  (pin_evt)
  );

  pd_state_ctrl u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pin_i      (pin_evt),
    .sw_up_i    (sw_up_i),
    .sw_down_i  (sw_down_i),
    .sw_off_o   (sw_off),
    .pwr_down_o (pd_int)
  );

  pd_abort_track u_abort (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .pwr_down_i    (pd_int),
    .conv_active_i (conv_active_i),
    .invalid_o     (result_invalid_o)
  );

  assign pwr_down_o = pd_int;
endmodule

// File: rtl/pd_arbiter_chk.sv
module pd_arbiter_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic sw_up_i,
  input logic sw_down_i,
  input logic conv_active_i,
  input logic pwr_down_o,
  input logic result_invalid_o,
  input logic pin_level,
  input logic pin_fall,
  input logic sw_off
);
  logic [1:0] age_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          age_q <= '0;
    else if (age_q != 2'd3) age_q <= age_q + 2'd1;
  end

  AST_RESET_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q == 2'd0) |-> (!pwr_down_o && !result_invalid_o)); // R1

  AST_PIN_FORCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pin_level |=> (pwr_down_o || !pin_level)); // R2

  AST_UP_BLOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pin_level && sw_up_i && sw_off) |=> sw_off); // R3

  AST_SW_DOWN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sw_down_i && !pin_fall) |=> pwr_down_o); // R4

  AST_SW_UP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sw_up_i && !sw_down_i && !pin_level) |=> !sw_off); // R5

  AST_PIN_WAKE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pin_fall |=> !sw_off); // R6 R7

  AST_ABORT_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q != 2'd0 && $rose(pwr_down_o) && conv_active_i) |=> result_invalid_o); // R9
endmodule

bind pd_arbiter pd_arbiter_chk u_chk (
  .clk_i            (clk_i),
  .rst_ni           (rst_ni),
  .sw_up_i          (sw_up_i),
  .sw_down_i        (sw_down_i),
  .conv_active_i    (conv_active_i),
  .pwr_down_o       (pwr_down_o),
  .result_invalid_o (result_invalid_o),
  .pin_level        (pin_evt.level),
  .pin_fall         (pin_evt.fall),
  .sw_off           (sw_off)
);

// File: tb/pd_arbiter_tb.sv
module pd_arbiter_tb_top;
  localparam int STAGES = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pin = 1'b0, up = 1'b0, dn = 1'b0, act = 1'b0;
  logic pd_o, inv_o;

  int n_chk = 0, n_err = 0;
  bit done = 1'b0;

  // reference state
  logic [STAGES-1:0] m_chain;
  logic m_prev, m_sw, m_pdq, m_actq, m_runok, m_inv;

  always #2.5 clk = ~clk;

  pd_arbiter #(.SYNC_STAGES(STAGES)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .pd_pin_i(pin), .sw_up_i(up),
    .sw_down_i(dn), .conv_active_i(act),
    .pwr_down_o(pd_o), .result_invalid_o(inv_o)
  );

  function automatic logic m_pd();
    return m_chain[STAGES-1] | m_sw;
  endfunction

  task automatic m_reset();
    m_chain = '0; m_prev = 0; m_sw = 0; m_pdq = 0; m_actq = 0; m_runok = 0; m_inv = 0;
  endtask

  task automatic m_clock();
    logic lvl, fall, pd, arise, afall, nsw, nrun, ninv;
    lvl   = m_chain[STAGES-1];
    fall  = m_prev & ~lvl;
    pd    = m_pd();
    arise = act & ~m_actq;
    afall = ~act & m_actq;
    nsw = m_sw;
    if (fall) nsw = 0; else if (dn) nsw = 1; else if (up && !lvl) nsw = 0;
    nrun = m_runok;
    if (pd) nrun = 0; else if (arise) nrun = 1; else if (afall) nrun = 0;
    ninv = m_inv;
    if (pd && !m_pdq && act) ninv = 1;
    else if (afall && m_runok && !pd) ninv = 0;
    m_prev = lvl; m_chain = {m_chain[STAGES-2:0], pin};
    m_sw = nsw; m_runok = nrun; m_inv = ninv; m_pdq = pd; m_actq = act;
  endtask

  task automatic check(input string tag);
    n_chk++;
    if (pd_o !== m_pd()) begin
      n_err++;
      $display("FAIL %s pwr_down_o actual=%0b expected=%0b", tag, pd_o, m_pd());
    end
    n_chk++;
    if (inv_o !== m_inv) begin
      n_err++;
      $display("FAIL %s result_invalid_o actual=%0b expected=%0b", tag, inv_o, m_inv);
    end
  endtask

  // called at a negedge; drives, clocks, then checks at the following negedge
  task automatic step(input logic p, input logic u, input logic d, input logic a, input string tag);
    pin = p; up = u; dn = d; act = a;
    @(posedge clk);
    #1 m_clock();
    @(negedge clk);
    check(tag);
  endtask

  task automatic expect_pd(input logic e, input string tag);
    n_chk++;
    if (pd_o !== e) begin
      n_err++;
      $display("FAIL %s directed pwr_down_o actual=%0b expected=%0b", tag, pd_o, e);
    end
  endtask

  task automatic expect_inv(input logic e, input string tag);
    n_chk++;
    if (inv_o !== e) begin
      n_err++;
      $display("FAIL %s directed result_invalid_o actual=%0b expected=%0b", tag, inv_o, e);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        n_chk++; n_err++;
        $display("FAIL watchdog expired");
        finish_run();
      end
    end
  end

  initial begin
    void'($urandom(32'd1357));
    m_reset();
    repeat (3) @(negedge clk);
    check("R1 in reset");
    rst_n = 1'b1;
    @(negedge clk);
    step(0, 0, 0, 0, "R1");
    expect_pd(0, "R1"); expect_inv(0, "R1");

    // R4 / R5
    step(0, 0, 1, 0, "R4");  expect_pd(1, "R4");
    step(0, 0, 0, 0, "R4");
    step(0, 1, 0, 0, "R5");  expect_pd(0, "R5");

    // R2 then R3
    step(1, 0, 0, 0, "R2");  expect_pd(0, "R2");
    step(1, 0, 0, 0, "R2");  expect_pd(1, "R2");
    step(1, 1, 0, 0, "R3");  expect_pd(1, "R3");
    step(1, 0, 0, 0, "R3");  expect_pd(1, "R3");
    step(0, 0, 0, 0, "R2");
    step(0, 0, 0, 0, "R2");  expect_pd(0, "R2");
    repeat (2) step(0, 0, 0, 0, "R2");

    // R6: software sleep cancelled by pin high-then-low
    step(0, 0, 1, 0, "R6");  expect_pd(1, "R6");
    repeat (3) step(1, 0, 0, 0, "R6");
    repeat (3) step(0, 0, 0, 0, "R6");
    expect_pd(0, "R6");

    // R7: strobe lands on the synchronized falling edge
    repeat (3) step(1, 0, 0, 0, "R7");
    step(0, 0, 0, 0, "R7");
    step(0, 0, 0, 0, "R7");
    step(0, 0, 1, 0, "R7");  expect_pd(0, "R7");
    step(0, 0, 0, 0, "R7");  expect_pd(0, "R7");

    // R8
    step(0, 1, 1, 0, "R8");  expect_pd(1, "R8");
    step(0, 1, 0, 0, "R8");  expect_pd(0, "R8");

    // R9: power-down lands in a conversion
    step(0, 0, 0, 1, "R9");
    step(0, 0, 1, 1, "R9");  expect_pd(1, "R9");
    step(0, 0, 0, 1, "R9");  expect_inv(1, "R9");
    step(0, 0, 0, 0, "R10"); expect_inv(1, "R10 aborted end keeps flag");
    step(0, 1, 0, 0, "R10");
    step(0, 0, 0, 1, "R10");
    step(0, 0, 0, 1, "R10"); expect_inv(1, "R10");
    step(0, 0, 0, 0, "R10"); expect_inv(0, "R10");

    // random traffic
    for (int i = 0; i < 4000; i++) begin
      logic p, u, d, a;
      p = (($urandom % 8) == 0) ? ~pin : pin;
      u = (($urandom % 6) == 0);
      d = (($urandom % 9) == 0);
      a = (($urandom % 5) == 0) ? ~act : act;
      step(p, u, d, a, "R2-R10 random");
    end
    finish_run();
  end
endmodule